// File: doc/BRIEF.md
# External Interrupt Status and Enable Controller

This block gathers the interrupt sources of a processor subsystem into one 32-bit status register, gated bit by bit by a 32-bit enable register. The sources are five external lines, a serial receive event, a serial transmit event, four DMA channel completions and a critical input. A status bit is set only when its enable bit is already 1 at the moment its source asserts. Any non-critical bit that is set this way also raises an external pending flag.

That flag is combined with two timer requests, one from a periodic timer and one from a fixed-interval timer. The result is a single non-critical request to the core, together with a vector offset. The request is gated by the core's global interrupt-enable input. The critical input follows a separate path that is never gated: it produces a one-cycle critical request with its own offset.

Software reaches both registers over a simple register bus. A write to status clears every bit written as 1. A write to enable stores the new value and removes any status bit that the new value disables.

The non-critical request follows valid/ready rules. `irq_req` is the valid signal and `irq_ack` is the ready signal. A request stays asserted, with a stable offset, until the core acknowledges it or drops `gie`. An acknowledge consumes only the class offered in that cycle, and an acknowledge with no request has no effect. The critical request cannot be stalled and is a pulse.

Top module: `extint_ctrl`

## Requirements
- R1: Status bit mapping: external line k (k = 0..4) sets bit 4−k, serial receive sets bit 27, serial transmit sets bit 26, DMA channel n (n = 0..3) sets bit 23−n, and the critical input sets bit 31.
- R2: A source event sets its status bit only if the matching enable bit was 1 before the event's clock edge. Otherwise the event leaves status unchanged and raises no request. External lines and the critical input act on their rising edge. Serial and DMA inputs act in every cycle they are high.
- R3: A bus write with `reg_sel`=0 clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R4: A bus write with `reg_sel`=1 stores the value into enable and clears every status bit whose new enable bit is 0. `reg_rdata` returns enable when `reg_sel`=1 and status when `reg_sel`=0.
- R5: A falling edge on external line k clears status bit 4−k.
- R6: A latched non-critical event sets the external pending flag. `irq_req` is high only while `gie`=1 and some class is pending. It remains high until acknowledged.
- R7: Priority and offsets: external pending gives 0x0500, then the periodic timer gives 0x1000, then the fixed-interval timer gives 0x1010. `irq_ofs` reads 0 when there is no request.
- R8: A rising edge on `crit_in` while enable bit 31 is 1 sets status bit 31. In the next cycle it gives `crit_req`=1 for exactly one cycle with `crit_ofs`=0x0100, whatever the value of `gie`.
- R9: `irq_ack` while `irq_req`=1 clears only the pending flag of the class being offered.
- R10: Sources that assert in the same cycle all latch their enabled status bits together.
- R11: After reset, status, enable, all pending flags, `irq_req` and `crit_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_line | input | 5 | External interrupt lines (level) |
| srx_evt | input | 1 | Serial receive event |
| stx_evt | input | 1 | Serial transmit event |
| dma_done | input | 4 | DMA channel completion events |
| crit_in | input | 1 | Critical interrupt input |
| pit_req | input | 1 | Periodic timer request strobe |
| fit_req | input | 1 | Fixed-interval timer request strobe |
| gie | input | 1 | Global interrupt enable from the core |
| irq_ack | input | 1 | Ready/acknowledge for the non-critical request |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Non-critical request (valid) |
| irq_ofs | output | 16 | Vector offset of the non-critical request |
| crit_req | output | 1 | Critical request pulse |
| crit_ofs | output | 16 | Vector offset of the critical request |

## Verification
Each source event, each bus write and each acknowledge takes effect at the first rising edge that samples it. Status, the pending flags and `irq_req`/`irq_ofs` therefore reflect the stimulus one cycle later. `crit_req` appears in that same cycle and is gone in the next. `reg_rdata` and the `gie` gating are combinational, so they follow the register state within the same cycle. The bench drives inputs on falling edges and advances its reference model just after each rising edge, comparing every output there. Directed checks read back registers on the falling edge that follows a stimulus.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int REG_W       = 32;
  localparam int OFS_W       = 16;
  localparam int N_EXT       = 5;
  localparam int N_DMA       = 4;
  localparam int EXT_TOP_BIT = 4;
  localparam int DMA_LOW_BIT = 20;
  localparam int SRX_BIT     = 27;
  localparam int STX_BIT     = 26;
  localparam int CRIT_BIT    = 31;

  localparam logic [OFS_W-1:0] OFS_EXT  = 16'h0500;
  localparam logic [OFS_W-1:0] OFS_PIT  = 16'h1000;
  localparam logic [OFS_W-1:0] OFS_FIT  = 16'h1010;
  localparam logic [OFS_W-1:0] OFS_CRIT = 16'h0100;

  typedef enum logic [1:0] {CLS_NONE, CLS_EXT, CLS_PIT, CLS_FIT} req_cls_e;

  function automatic int ext_bit(input int k);
    return EXT_TOP_BIT - k;
  endfunction

  function automatic int dma_bit(input int n);
    return DMA_LOW_BIT + N_DMA - 1 - n;
  endfunction
endpackage

// File: rtl/extint_srcmap.sv
module extint_srcmap
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_line,
  input  logic             srx_evt,
  input  logic             stx_evt,
  input  logic [N_DMA-1:0] dma_done,
  input  logic             crit_in,
  output logic [REG_W-1:0] rise_mask,
  output logic [REG_W-1:0] fall_mask
);
  logic [N_EXT-1:0] ext_q;
  logic             crit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q  <= '0;
      crit_q <= 1'b0;
    end else begin
      ext_q  <= ext_line;
      crit_q <= crit_in;
    end
  end

  always_comb begin
    rise_mask = '0;
    fall_mask = '0;
    for (int k = 0; k < N_EXT; k++) begin
      rise_mask[ext_bit(k)] = ext_line[k] & ~ext_q[k];
      fall_mask[ext_bit(k)] = ~ext_line[k] & ext_q[k];
    end
    for (int n = 0; n < N_DMA; n++) begin
      rise_mask[dma_bit(n)] = dma_done[n];
    end
    rise_mask[SRX_BIT]  = srx_evt;
    rise_mask[STX_BIT]  = stx_evt;
    rise_mask[CRIT_BIT] = crit_in & ~crit_q;
  end

  AST_NO_RISE_FALL_SAME_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_mask & fall_mask) == '0); // R5
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] rise_mask,
  input  logic [REG_W-1:0] fall_mask,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] status,
  output logic [REG_W-1:0] enable,
  output logic [REG_W-1:0] latched
);
  logic [REG_W-1:0] status_nx;
  logic [REG_W-1:0] enable_nx;

  assign latched = rise_mask & enable;

  always_comb begin
    status_nx = status;
    enable_nx = enable;
    if (reg_we && !reg_sel) status_nx = status_nx & ~reg_wdata;
    status_nx = status_nx & ~fall_mask;
    status_nx = status_nx | latched;
    if (reg_we && reg_sel) begin
      enable_nx = reg_wdata;
      status_nx = status_nx & reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= status_nx;
      enable <= enable_nx;
    end
  end

  AST_STATUS_WITHIN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~enable) == '0); // R4
  AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    |fall_mask |=> ((status & $past(fall_mask)) == '0)); // R5
  AST_LATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|latched && !(reg_we && reg_sel)) |=> ((status & $past(latched)) == $past(latched))); // R10
endmodule

// File: rtl/extint_arb.sv
module extint_arb
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_set,
  input  logic             crit_set,
  input  logic             pit_req,
  input  logic             fit_req,
  input  logic             gie,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [OFS_W-1:0] irq_ofs,
  output logic             crit_req,
  output logic [OFS_W-1:0] crit_ofs
);
  logic     ext_p, pit_p, fit_p, crit_q;
  req_cls_e offer;
  logic     take;

  always_comb begin
    offer = CLS_NONE;
    if (gie) begin
      if (ext_p)      offer = CLS_EXT;
      else if (pit_p) offer = CLS_PIT;
      else if (fit_p) offer = CLS_FIT;
    end
  end

  assign irq_req = (offer != CLS_NONE);
  assign take    = irq_req & irq_ack;

  always_comb begin
    unique case (offer)
      CLS_EXT: irq_ofs = OFS_EXT;
      CLS_PIT: irq_ofs = OFS_PIT;
      CLS_FIT: irq_ofs = OFS_FIT;
      default: irq_ofs = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_p  <= 1'b0;
      pit_p  <= 1'b0;
      fit_p  <= 1'b0;
      crit_q <= 1'b0;
    end else begin
      ext_p  <= ext_set | (ext_p & ~(take && offer == CLS_EXT));
      pit_p  <= pit_req | (pit_p & ~(take && offer == CLS_PIT));
      fit_p  <= fit_req | (fit_p & ~(take && offer == CLS_FIT));
      crit_q <= crit_set;
    end
  end

  assign crit_req = crit_q;
  assign crit_ofs = crit_q ? OFS_CRIT : '0;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack && gie) |=> (irq_req || !gie)); // R6
  AST_OFS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack && !ext_set && !pit_req && !fit_req) |=> (!irq_req || $stable(irq_ofs))); // R7
  AST_CRIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    crit_req |=> !crit_req); // R8
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_line,
  input  logic             srx_evt,
  input  logic             stx_evt,
  input  logic [N_DMA-1:0] dma_done,
  input  logic             crit_in,
  input  logic             pit_req,
  input  logic             fit_req,
  input  logic             gie,
  input  logic             irq_ack,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_req,
  output logic [OFS_W-1:0] irq_ofs,
  output logic             crit_req,
  output logic [OFS_W-1:0] crit_ofs
);
  localparam logic [REG_W-1:0] CRIT_MASK = REG_W'(1) << CRIT_BIT;

  logic [REG_W-1:0] rise_mask, fall_mask, status, enable, latched;

  extint_srcmap u_map (
    .clk(clk), .rst_n(rst_n), .ext_line(ext_line), .srx_evt(srx_evt),
    .stx_evt(stx_evt), .dma_done(dma_done), .crit_in(crit_in),
    .rise_mask(rise_mask), .fall_mask(fall_mask)
  );

  extint_regs u_regs (
    .clk(clk), .rst_n(rst_n), .rise_mask(rise_mask), .fall_mask(fall_mask),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .status(status), .enable(enable), .latched(latched)
  );

  extint_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .ext_set(|(latched & ~CRIT_MASK)), .crit_set(|(latched & CRIT_MASK)),
    .pit_req(pit_req), .fit_req(fit_req), .gie(gie), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_ofs(irq_ofs), .crit_req(crit_req), .crit_ofs(crit_ofs)
  );

  assign reg_rdata = reg_sel ? enable : status;

  AST_CRIT_MARKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    crit_req |-> status[CRIT_BIT]); // R8
  AST_REQ_OFS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_ofs == OFS_EXT || irq_ofs == OFS_PIT || irq_ofs == OFS_FIT)); // R7
endmodule

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;
  logic clk = 0, rst_n = 0;
  logic [4:0] ext_line = 0;
  logic srx_evt = 0, stx_evt = 0, crit_in = 0, pit_req = 0, fit_req = 0;
  logic [3:0] dma_done = 0;
  logic gie = 0, irq_ack = 0, reg_we = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq_req, crit_req;
  logic [15:0] irq_ofs, crit_ofs;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  extint_ctrl i_extint_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_line(ext_line), .srx_evt(srx_evt),
    .stx_evt(stx_evt), .dma_done(dma_done), .crit_in(crit_in),
    .pit_req(pit_req), .fit_req(fit_req), .gie(gie), .irq_ack(irq_ack),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_ofs(irq_ofs),
    .crit_req(crit_req), .crit_ofs(crit_ofs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_stat = 0, m_en = 0;
  bit m_ep = 0, m_pp = 0, m_fp = 0, m_crit = 0;
  logic [4:0] m_prev_ext = 0;
  logic m_prev_crit = 0;

  function automatic logic [15:0] m_ofs();
    if (!gie) return 16'h0;
    if (m_ep) return 16'h0500;
    if (m_pp) return 16'h1000;
    if (m_fp) return 16'h1010;
    return 16'h0;
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] ev;
    logic [15:0] off;
    #1;
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_ep = 0; m_pp = 0; m_fp = 0; m_crit = 0;
      m_prev_ext = 0; m_prev_crit = 0;
    end else begin
      off = m_ofs();
      if (irq_ack && off == 16'h0500) m_ep = 0;
      if (irq_ack && off == 16'h1000) m_pp = 0;
      if (irq_ack && off == 16'h1010) m_fp = 0;
      if (reg_we && !reg_sel) m_stat = m_stat & ~reg_wdata;
      ev = 0;
      for (int k = 0; k < 5; k++) begin
        if (!ext_line[k] && m_prev_ext[k]) m_stat[4-k] = 1'b0;
        if (ext_line[k] && !m_prev_ext[k]) ev[4-k] = 1'b1;
      end
      for (int n = 0; n < 4; n++) if (dma_done[n]) ev[23-n] = 1'b1;
      if (srx_evt) ev[27] = 1'b1;
      if (stx_evt) ev[26] = 1'b1;
      if (crit_in && !m_prev_crit) ev[31] = 1'b1;
      ev = ev & m_en;
      m_stat = m_stat | ev;
      if (ev[30:0] != 0) m_ep = 1;
      if (pit_req) m_pp = 1;
      if (fit_req) m_fp = 1;
      m_crit = ev[31];
      if (reg_we && reg_sel) begin
        m_en = reg_wdata;
        m_stat = m_stat & reg_wdata;
      end
      m_prev_ext = ext_line;
      m_prev_crit = crit_in;
    end
    chk("R4 model rdata", reg_rdata, reg_sel ? m_en : m_stat);
    chk("R6 model irq_req", {31'b0, irq_req}, {31'b0, (m_ofs() != 0)});
    chk("R7 model irq_ofs", {16'b0, irq_ofs}, {16'b0, m_ofs()});
    chk("R8 model crit_req", {31'b0, crit_req}, {31'b0, m_crit});
    chk("R8 model crit_ofs", {16'b0, crit_ofs}, m_crit ? 32'h100 : 32'h0);
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic sel, input logic [31:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    cyc();
    reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd(input string tag, input logic sel, input logic [31:0] exp);
    reg_sel = sel;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic ack();
    irq_ack = 1;
    cyc();
    irq_ack = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R11 reset state
    rd("R11 status after reset", 0, 32'h0);
    rd("R11 enable after reset", 1, 32'h0);
    chk("R11 irq_req after reset", {31'b0, irq_req}, 32'h0);
    chk("R11 crit_req after reset", {31'b0, crit_req}, 32'h0);

    // R2: event with enable clear is ignored
    ext_line[0] = 1; srx_evt = 1; dma_done = 4'b0001;
    cyc(); srx_evt = 0; dma_done = 0;
    rd("R2 disabled events ignored", 0, 32'h0);
    chk("R2 no request when disabled", {31'b0, irq_req}, 32'h0);
    ext_line[0] = 0; cyc();

    // R4: enable write and readback
    bus_wr(1, 32'h7FFF_FFFF);
    rd("R4 enable readback", 1, 32'h7FFF_FFFF);

    // R1/R6: ext line 0 -> bit 4, gated by gie
    ext_line[0] = 1; cyc();
    rd("R1 ext0 maps to bit 4", 0, 32'h0000_0010);
    chk("R6 no irq_req while gie low", {31'b0, irq_req}, 32'h0);
    gie = 1; #1;
    chk("R6 irq_req with gie", {31'b0, irq_req}, 32'h1);
    chk("R7 ext offset", {16'b0, irq_ofs}, 32'h0500);
    cyc();
    chk("R6 request held without ack", {31'b0, irq_req}, 32'h1);
    ack();
    chk("R9 ack clears ext pending", {31'b0, irq_req}, 32'h0);
    rd("R9 ack leaves status", 0, 32'h0000_0010);

    // R5: falling edge clears
    ext_line[0] = 0; cyc();
    rd("R5 fall clears bit 4", 0, 32'h0);

    // R10/R1: simultaneous sources
    ext_line[4:1] = 4'hF; srx_evt = 1; stx_evt = 1; dma_done = 4'hF;
    cyc(); srx_evt = 0; stx_evt = 0; dma_done = 0;
    rd("R10 simultaneous latch", 0, 32'h0CF0_000F);

    // R3: write-one-to-clear
    bus_wr(0, 32'h0C00_000F);
    rd("R3 W1C clears written ones", 0, 32'h00F0_0000);

    // R4: enable write masks status
    bus_wr(1, 32'h0030_0000);
    rd("R4 enable masks status", 0, 32'h0030_0000);
    rd("R4 enable stored", 1, 32'h0030_0000);
    ext_line = 0;
    ack();
    chk("R9 ext acked", {31'b0, irq_req}, 32'h0);

    // R7/R9: timer priority
    pit_req = 1; fit_req = 1; cyc(); pit_req = 0; fit_req = 0;
    chk("R7 pit before fit", {16'b0, irq_ofs}, 32'h1000);
    dma_done = 4'b0100; cyc(); dma_done = 0;
    chk("R7 ext before pit", {16'b0, irq_ofs}, 32'h0500);
    ack();
    chk("R9 pit remains after ext ack", {16'b0, irq_ofs}, 32'h1000);
    ack();
    chk("R9 fit after pit ack", {16'b0, irq_ofs}, 32'h1010);
    ack();
    chk("R9 all classes consumed", {31'b0, irq_req}, 32'h0);
    ack();
    chk("R9 stray ack no effect", {31'b0, irq_req}, 32'h0);

    // R8: critical path, independent of gie
    gie = 0;
    crit_in = 1; cyc();
    chk("R8 crit needs enable bit31", {31'b0, crit_req}, 32'h0);
    crit_in = 0; cyc();
    bus_wr(1, 32'h8000_0000);
    crit_in = 1; cyc();
    chk("R8 crit_req pulse", {31'b0, crit_req}, 32'h1);
    chk("R8 crit offset", {16'b0, crit_ofs}, 32'h0100);
    rd("R8 status bit31 set", 0, 32'h8000_0000);
    chk("R8 no non-critical request", {31'b0, irq_req}, 32'h0);
    cyc();
    chk("R8 crit_req one cycle", {31'b0, crit_req}, 32'h0);
    crit_in = 0;
    repeat (3) cyc();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule